// File: doc/BRIEF.md
# GPIO Controller with Interrupt Detection

This block controls 32 general-purpose pins through a small memory-mapped register window of 0x20 bytes. Software sets an output value and an output-enable for each pin, and it can read back the pad levels after they pass through a two-flop synchronizer. Each pin also has a trigger detector. The detector watches the synchronized level for a low level, a high level, a rising edge or a falling edge. A per-pin override makes a pin fire on either edge instead.

Detected events latch into a status word, and software clears bits by writing ones to them. A mask word chooses which latched bits drive the single interrupt line. The interrupt line is registered. The register bus is a plain single-cycle interface: a write takes effect at the clock edge where the write enable is high, and read data follows the address combinationally.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A write to byte offset 0x00 stores the output value word. `pad_out` shows it from the next cycle, and a read at 0x00 returns it.
- R2: A write to offset 0x04 stores the direction word, which reads back at 0x04. `pad_oe` equals that word, and a 1 in bit n makes pin n an output.
- R3: A read at offset 0x08 returns the pad levels after two synchronizer flops, for every pin including pins set as outputs. A change on `pad_in` driven between clock edges is visible after the second following rising edge and not after the first.
- R4: Offset 0x0C holds the 2-bit trigger codes for pins 0-15, with pin n in bits [2n+1:2n]. Offset 0x10 holds the codes for pins 16-31, with pin 16+k in bits [2k+1:2k]. The codes are 0 = low level, 1 = high level, 2 = rising edge and 3 = falling edge. Both words read back as written.
- R5: In a level mode, a pin's status bit is set on every cycle that the synchronized level matches. It is set again right after a write-one-to-clear if the level still holds.
- R6: In an edge mode, the status bit is set only when the synchronized level moves in the chosen direction, judged against its value one cycle earlier. A move in the other direction has no effect.
- R7: Offset 0x1C holds the both-edges word, which reads back as written. When bit n is 1, pin n sets its status bit on either edge, whatever its trigger code.
- R8: The status word is at offset 0x18. Writing a 1 to bit n clears it, and writing a 0 leaves it unchanged. A write never sets a status bit, and a bit becomes set only through a detected event.
- R9: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R10: The mask word is at offset 0x14. `irq` is a register that holds the OR over all pins of (status AND mask), taken at the previous edge. It is 0 while the mask is 0.
- R11: After reset, the output value, direction, both trigger-code words, mask, both-edges word, `pad_out`, `pad_oe` and `irq` are all 0.
- R12: Writes to offset 0x08 are ignored. Accesses whose address bits [1:0] are not zero write nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address within the register window |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Output value for each pin |
| pad_oe | output | 32 | Output enable for each pin, 1 = drive |
| irq | output | 1 | Combined interrupt, registered |

## Verification
A detected event and a software write-one-to-clear can land on the same status bit in the same cycle. The bench provokes this by raising a pad in rising-edge mode and counting the two synchronizer stages. It then holds a clear of that bit on the bus for exactly the cycle in which the edge is seen. The bit must still read 1 afterwards. A level-mode pin whose level stays true is cleared as well, and that bit must read back set at once.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word index of each register (byte offset / 4)
  typedef enum logic [2:0] {
    RA_DATA   = 3'd0,
    RA_DIR    = 3'd1,
    RA_PAD    = 3'd2,
    RA_CFG_LO = 3'd3,
    RA_CFG_HI = 3'd4,
    RA_MASK   = 3'd5,
    RA_STAT   = 3'd6,
    RA_BOTH   = 3'd7
  } reg_idx_e;

  // Per-pin trigger code
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam int IDX_LSB = 2;
  localparam int IDX_W   = 3;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);

  // chain_q[0] is the newest sample
  logic [STAGES-1:0][W-1:0] chain_q, chain_d;
  logic [W-1:0]             prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], raw_i};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign sync_o = chain_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_trig_det.sv
module gpio_trig_det
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0]   lvl_i,
  input  logic [NPIN-1:0]   prev_i,
  input  logic [2*NPIN-1:0] code_i,
  input  logic [NPIN-1:0]   both_i,
  output logic [NPIN-1:0]   evt_o
);

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    trig_e code;
    logic  rise, fall, hit;

    assign code = trig_e'(code_i[2*p +: 2]);
    assign rise = lvl_i[p] & ~prev_i[p];
    assign fall = ~lvl_i[p] & prev_i[p];

    always_comb begin
      if (both_i[p]) begin
        hit = rise | fall;
      end else begin
        unique case (code)
          TRIG_LOW:  hit = ~lvl_i[p];
          TRIG_HIGH: hit = lvl_i[p];
          TRIG_RISE: hit = rise;
          TRIG_FALL: hit = fall;
          default:   hit = 1'b0;
        endcase
      end
    end

    assign evt_o[p] = hit;
  end

endmodule

// File: rtl/gpio_irq_stat.sv
module gpio_irq_stat #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] evt_i,
  input  logic [NPIN-1:0] clr_i,
  input  logic [NPIN-1:0] mask_i,
  output logic [NPIN-1:0] stat_o,
  output logic            irq_o
);

  logic [NPIN-1:0] stat_q, stat_d;
  logic            irq_q, irq_d;

  always_comb begin
    // a new event overrides a clear of the same bit
    stat_d = (stat_q & ~clr_i) | evt_i;
    irq_d  = |(stat_q & mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPIN     = 32,
  parameter int AW       = 5,
  parameter int SYNC_STG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic            irq,
  output logic [NPIN-1:0] pad_oe
);

  reg_idx_e        widx;
  logic            aligned;
  logic            wr_en;

  logic [NPIN-1:0] data_q, data_d;
  logic [NPIN-1:0] dir_q,  dir_d;
  logic [NPIN-1:0] cfg_lo_q, cfg_lo_d;
  logic [NPIN-1:0] cfg_hi_q, cfg_hi_d;
  logic [NPIN-1:0] mask_q, mask_d;
  logic [NPIN-1:0] both_q, both_d;

  logic [NPIN-1:0] lvl_sync, lvl_prev;
  logic [NPIN-1:0] evt_vec, clr_vec, stat_vec;

  assign widx    = reg_idx_e'(bus_addr[IDX_LSB +: IDX_W]);
  assign aligned = (bus_addr[IDX_LSB-1:0] == '0);
  assign wr_en   = bus_we & aligned;

  // register write next-state
  always_comb begin
    data_d   = data_q;
    dir_d    = dir_q;
    cfg_lo_d = cfg_lo_q;
    cfg_hi_d = cfg_hi_q;
    mask_d   = mask_q;
    both_d   = both_q;
    clr_vec  = '0;
    if (wr_en) begin
      unique case (widx)
        RA_DATA:   data_d   = bus_wdata;
        RA_DIR:    dir_d    = bus_wdata;
        RA_CFG_LO: cfg_lo_d = bus_wdata;
        RA_CFG_HI: cfg_hi_d = bus_wdata;
        RA_MASK:   mask_d   = bus_wdata;
        RA_STAT:   clr_vec  = bus_wdata;
        RA_BOTH:   both_d   = bus_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      both_q   <= '0;
    end else begin
      data_q   <= data_d;
      dir_q    <= dir_d;
      cfg_lo_q <= cfg_lo_d;
      cfg_hi_q <= cfg_hi_d;
      mask_q   <= mask_d;
      both_q   <= both_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      unique case (widx)
        RA_DATA:   bus_rdata = data_q;
        RA_DIR:    bus_rdata = dir_q;
        RA_PAD:    bus_rdata = lvl_sync;
        RA_CFG_LO: bus_rdata = cfg_lo_q;
        RA_CFG_HI: bus_rdata = cfg_hi_q;
        RA_MASK:   bus_rdata = mask_q;
        RA_STAT:   bus_rdata = stat_vec;
        RA_BOTH:   bus_rdata = both_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  gpio_in_sync #(.W(NPIN), .STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pad_in),
    .sync_o (lvl_sync),
    .prev_o (lvl_prev)
  );

  gpio_trig_det #(.NPIN(NPIN)) u_det (
    .lvl_i  (lvl_sync),
    .prev_i (lvl_prev),
    .code_i ({cfg_hi_q, cfg_lo_q}),
    .both_i (both_q),
    .evt_o  (evt_vec)
  );

  gpio_irq_stat #(.NPIN(NPIN)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_vec),
    .clr_i  (clr_vec),
    .mask_i (mask_q),
    .stat_o (stat_vec),
    .irq_o  (irq)
  );

  assign pad_out = data_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic            irq,
  input logic [NPIN-1:0] stat_vec,
  input logic [NPIN-1:0] mask_q,
  input logic [NPIN-1:0] evt_vec
);

  logic wr_ok;
  assign wr_ok = bus_we && (bus_addr[IDX_LSB-1:0] == '0);

  // R1
  data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_addr[IDX_LSB +: IDX_W] == RA_DATA) |=> (pad_out == $past(bus_wdata)));

  // R2
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_addr[IDX_LSB +: IDX_W] == RA_DIR) |=> (pad_oe == $past(bus_wdata)));

  // R8
  stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_vec & ~$past(stat_vec) & ~$past(evt_vec)) == '0));

  // R9
  evt_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_vec) & ~stat_vec) == '0));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq);

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .stat_vec  (stat_vec),
  .mask_q    (mask_q),
  .evt_vec   (evt_vec)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;

  localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
                         A_CLO = 5'h0C, A_CHI = 5'h10, A_MASK = 5'h14,
                         A_STAT = 5'h18, A_BOTH = 5'h1C;
  localparam logic [31:0] ALL_RISE = 32'hAAAA_AAAA;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .irq       (irq),
    .pad_oe    (pad_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic quiet();
    pad_in = '0;
    settle(5);
    wr(A_MASK, '0);
    wr(A_STAT, '1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_DATA, v); chk("R11 data", v, 0);
    rd(A_DIR,  v); chk("R11 dir", v, 0);
    rd(A_CLO,  v); chk("R11 cfg lo", v, 0);
    rd(A_CHI,  v); chk("R11 cfg hi", v, 0);
    rd(A_MASK, v); chk("R11 mask", v, 0);
    rd(A_BOTH, v); chk("R11 both", v, 0);
    chk("R11 pad_out", pad_out, 0);
    chk("R11 pad_oe", pad_oe, 0);
    chk("R11 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_setup();
    logic [31:0] v;
    wr(A_CLO, ALL_RISE);
    wr(A_CHI, ALL_RISE);
    settle(2);
    wr(A_STAT, '1);
    rd(A_STAT, v); chk("R8 clear all", v, 0);
  endtask

  task automatic t_data_dir();
    logic [31:0] v;
    wr(A_DATA, 32'hA5A5_5A5A);
    rd(A_DATA, v); chk("R1 readback", v, 32'hA5A5_5A5A);
    chk("R1 pad_out", pad_out, 32'hA5A5_5A5A);
    wr(A_DIR, 32'h0F0F_00FF);
    rd(A_DIR, v); chk("R2 readback", v, 32'h0F0F_00FF);
    chk("R2 pad_oe", pad_oe, 32'h0F0F_00FF);
    wr(A_DATA + 5'd1, 32'h0);
    rd(A_DATA, v); chk("R12 unaligned write", v, 32'hA5A5_5A5A);
    rd(A_DATA + 5'd2, v); chk("R12 unaligned read", v, 0);
  endtask

  task automatic t_pad();
    logic [31:0] v;
    quiet();
    pad_in = 32'h1234_5678;
    settle(1);
    rd(A_PAD, v); chk("R3 one stage", v, 0);
    settle(1);
    rd(A_PAD, v); chk("R3 two stages incl outputs", v, 32'h1234_5678);
    wr(A_PAD, 32'hFFFF_FFFF);
    rd(A_PAD, v); chk("R12 pad read-only", v, 32'h1234_5678);
    rd(A_DATA, v); chk("R12 data untouched", v, 32'hA5A5_5A5A);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    quiet();
    wr(A_CHI, 32'hAAAA_ABAA);   // pin 20 -> code 3 (falling)
    rd(A_CHI, v); chk("R4 cfg hi readback", v, 32'hAAAA_ABAA);
    rd(A_CLO, v); chk("R4 cfg lo readback", v, ALL_RISE);
    pad_in = (32'd1 << 3) | (32'd1 << 20);
    settle(5);
    rd(A_STAT, v); chk("R6 rise only", v, 32'h0000_0008);
    pad_in = '0;
    settle(5);
    rd(A_STAT, v); chk("R6 fall on pin 20", v, 32'h0010_0008);
    wr(A_CHI, ALL_RISE);
  endtask

  task automatic t_level();
    logic [31:0] v;
    quiet();
    pad_in = 32'h0000_0060;
    settle(5);
    wr(A_CLO, 32'hAAAA_86AA);   // pin 5 code 1 (high), pin 6 code 0 (low)
    wr(A_STAT, '1);
    rd(A_STAT, v); chk("R5 level high re-set after clear", v, 32'h0000_0020);
    pad_in = 32'h0000_0020;
    settle(5);
    rd(A_STAT, v); chk("R5 level low", v, 32'h0000_0060);
    pad_in = 32'h0000_0000;
    settle(5);
    wr(A_STAT, '1);
    rd(A_STAT, v); chk("R5 only held level stays", v, 32'h0000_0040);
    wr(A_CLO, ALL_RISE);
  endtask

  task automatic t_both();
    logic [31:0] v;
    quiet();
    wr(A_BOTH, 32'h0000_0200);
    rd(A_BOTH, v); chk("R7 readback", v, 32'h0000_0200);
    pad_in = 32'h0000_0600;
    settle(5);
    rd(A_STAT, v); chk("R7 rise", v, 32'h0000_0600);
    wr(A_STAT, '1);
    pad_in = '0;
    settle(5);
    rd(A_STAT, v); chk("R7 fall only with override", v, 32'h0000_0200);
    wr(A_BOTH, '0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    quiet();
    pad_in = 32'h7;
    settle(5);
    rd(A_STAT, v); chk("R8 three set", v, 32'h7);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); chk("R8 clear one", v, 32'h5);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R8 zero write keeps", v, 32'h5);
    wr(A_STAT, 32'hFFFF_0000);
    rd(A_STAT, v); chk("R8 write never sets", v, 32'h5);
  endtask

  task automatic t_irq();
    quiet();
    pad_in = 32'h1;
    settle(5);
    chk("R10 masked", {31'd0, irq}, 0);
    wr(A_MASK, 32'h1);
    chk("R10 registered lag", {31'd0, irq}, 0);
    settle(1);
    chk("R10 asserted", {31'd0, irq}, 1);
    wr(A_STAT, 32'h1);
    settle(1);
    chk("R10 drops after clear", {31'd0, irq}, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    quiet();
    pad_in = 32'h0000_1000;     // event seen two edges later
    @(negedge clk);
    @(negedge clk);
    bus_addr = A_STAT; bus_wdata = 32'h0000_1000; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(A_STAT, v); chk("R9 event beats clear", v, 32'h0000_1000);
    wr(A_STAT, 32'h0000_1000);
    rd(A_STAT, v); chk("R9 later clear works", v, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    settle(3);
    rst_n = 1'b1;
    settle(1);
    t_reset();
    t_setup();
    t_data_dir();
    t_pad();
    t_edge();
    t_level();
    t_both();
    t_w1c();
    t_irq();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule